// File: doc/BRIEF.md
# Bayer Quad Colour Transform

This block sits between a sensor cleanup stage and a wavelet coder. It takes a raw mosaic stream, one pixel per accepted transfer, in raster order. The mosaic repeats a 2x2 tile: red and first green on even rows, second green and blue on odd rows. For each tile it emits one four-channel sample: a luminance value `Y`, two chroma differences `U` and `V`, and a green difference `D`. The goal is to remove correlation between the four raw samples before entropy coding. The arithmetic is integer lifting, so the four raw samples can be recovered exactly and a lossless coding path stays lossless.

The stream is never held as a frame. One line buffer keeps the (red, first green) pair of every tile on the current even row. The tile is finished when its blue sample arrives on the following odd row. The input and output both use a valid/ready handshake. A start-of-frame flag and an end-of-line flag travel with the pixels and come out aligned with the tile samples.

A four-state controller tracks where the next pixel falls in the tile:

- `ST_EVEN_L` waits for red.
- `ST_EVEN_R` waits for the first green.
- `ST_ODD_L` waits for the second green.
- `ST_ODD_R` waits for blue.

The transitions are:

- `EVEN_L→EVEN_R` and `ODD_L→ODD_R` on any accepted pixel.
- `EVEN_R→EVEN_L` and `ODD_R→ODD_L` on an accepted pixel without end-of-line.
- `EVEN_R→ODD_L` and `ODD_R→EVEN_L` on an accepted pixel with end-of-line.
- From any state to `ST_EVEN_R` on an accepted pixel carrying start-of-frame. That pixel is taken as the red of tile column 0.

Lines must have an even pixel count, at most `2*MAX_QUADS`.

Top module: `bayer_quad_ct`

## Requirements
- R1: While reset is held and right after it, `out_valid` is 0 and `in_ready` is 1.
- R2: For a tile with samples R, G1, G2, B (unsigned, `PIX_W` bits), the outputs are computed with arithmetic shifts that round toward minus infinity:
  - G = (G1+G2)>>1
  - D = G1-G2
  - U = R-G
  - V = B-G
  - Y = G + ((U+V)>>2)

  U, V and D are signed and `PIX_W+1` bits wide. Y is unsigned and `PIX_W` bits wide.
- R3: The outputs invert exactly. G = Y-((U+V)>>2), R = U+G, B = V+G, G1 = G+((D+1)>>1), G2 = G1-D, and every recovered value lies in 0 to 2^PIX_W-1.
- R4: Exactly one output sample is produced per tile. A sample appears only in the cycle after a blue (odd row, odd column) pixel is accepted, and never while even rows are streaming.
- R5: Samples leave in raster tile order. Each one combines even-row pixels at columns 2j and 2j+1 with the odd-row pixels at the same two columns.
- R6: `out_sof` is 1 on the first tile sample of each frame and 0 on every other sample.
- R7: `out_eol` is 1 exactly on the sample whose blue pixel carried `in_eol`, which is the last tile of each row pair.
- R8: Backpressure:
  - While `out_valid` is 1 and `out_ready` is 0, the output sample and its flags hold unchanged.
  - `in_ready` drops only when the next pixel is a blue and the held sample has not yet been taken.
  - Red and green pixels are still accepted during the stall.
- R9: An accepted pixel with `in_sof` restarts the tile position at row 0, column 0. Any unfinished tile is abandoned and yields no output.
- R10: Extreme tiles follow R2 with no wrap. All-maximum gives Y=2^PIX_W-1 and U=V=D=0. First green at maximum with the rest zero gives D=2^PIX_W-1 and U=V=-(2^(PIX_W-1)-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can accept the input pixel |
| in_pix | input | PIX_W | Raw mosaic sample |
| in_sof | input | 1 | Pixel is the first of a frame (row 0, column 0) |
| in_eol | input | 1 | Pixel is the last of its row |
| out_valid | output | 1 | Output tile sample present |
| out_ready | input | 1 | Downstream takes the sample |
| out_y | output | PIX_W | Luminance, unsigned |
| out_u | output | PIX_W+1 | Red chroma difference, signed |
| out_v | output | PIX_W+1 | Blue chroma difference, signed |
| out_d | output | PIX_W+1 | Green difference G1-G2, signed |
| out_sof | output | 1 | Sample is the first tile of a frame |
| out_eol | output | 1 | Sample is the last tile of its row pair |

## Verification
The rounding corners are the first target: extreme tiles where (U+V) is negative and odd in its low bits. A design using a logical shift or truncating toward zero there would give a Y that is off by one or wrapped, and the exact inverse would then fail. Pairing is checked with multi-tile, multi-row frames whose pixel values all differ. A line buffer read or written at the wrong column would mix the greens of neighbouring tiles. A stall with the blue pixel waiting tests that the held sample stays stable and that input is throttled only at that point; a design that overwrote the held sample would lose one tile. A start-of-frame in mid-tile tests that the stale half-tile is discarded and not emitted with the wrong flags.

// File: rtl/bqct_pkg.sv
package bqct_pkg;

    // Position of the next expected pixel inside the 2x2 tile
    typedef enum logic [1:0] {
        ST_EVEN_L = 2'd0,   // red
        ST_EVEN_R = 2'd1,   // first green
        ST_ODD_L  = 2'd2,   // second green
        ST_ODD_R  = 2'd3    // blue
    } bq_state_e;

endpackage

// File: rtl/bqct_line_buf.sv
// One even-row line of (red, first green) pairs, indexed by tile column.
module bqct_line_buf #(
    parameter int DW    = 24,
    parameter int DEPTH = 32,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == AW'(i))) begin
                mem[i] <= wr_data;
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/bqct_lift.sv
// Integer lifting from one raw tile to Y/U/V/D. Purely combinational.
module bqct_lift #(
    parameter int PIX_W = 12
) (
    input  logic [PIX_W-1:0]        r,
    input  logic [PIX_W-1:0]        g1,
    input  logic [PIX_W-1:0]        g2,
    input  logic [PIX_W-1:0]        b,
    output logic [PIX_W-1:0]        y,
    output logic signed [PIX_W:0]   u,
    output logic signed [PIX_W:0]   v,
    output logic signed [PIX_W:0]   d
);

    localparam int EW = PIX_W + 2;

    logic [PIX_W:0]          g_sum;
    logic [PIX_W-1:0]        g_avg;
    logic signed [EW-1:0]    g_ext;
    logic signed [EW-1:0]    uv_sum;
    logic signed [EW-1:0]    uv_q;

    always_comb begin
        g_sum  = {1'b0, g1} + {1'b0, g2};
        g_avg  = PIX_W'(g_sum >> 1);
        d      = $signed({1'b0, g1}) - $signed({1'b0, g2});
        u      = $signed({1'b0, r}) - $signed({1'b0, g_avg});
        v      = $signed({1'b0, b}) - $signed({1'b0, g_avg});
        g_ext  = $signed({2'b00, g_avg});
        uv_sum = EW'(u) + EW'(v);
        uv_q   = uv_sum >>> 2;
        y      = PIX_W'(g_ext + uv_q);
    end

endmodule

// File: rtl/bqct_ctrl.sv
// Tile-position state machine and tile column counter.
module bqct_ctrl
    import bqct_pkg::*;
#(
    parameter int MAX_QUADS = 32,
    parameter int QW        = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_acc,
    input  logic          in_sof,
    input  logic          in_eol,
    output bq_state_e     state,
    output logic [QW-1:0] qcol,
    output logic          take_r,
    output logic          wr_line,
    output logic          take_g2,
    output logic          fire
);

    localparam logic [QW-1:0] QLAST = QW'(MAX_QUADS - 1);

    bq_state_e     state_q, state_d;
    logic [QW-1:0] qcol_q;

    // state register and column counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EVEN_L;
            qcol_q  <= '0;
        end else begin
            state_q <= state_d;
            if (in_acc) begin
                if (in_sof) begin
                    qcol_q <= '0;
                end else if (state_q == ST_EVEN_R || state_q == ST_ODD_R) begin
                    if (in_eol || qcol_q == QLAST) begin
                        qcol_q <= '0;
                    end else begin
                        qcol_q <= qcol_q + 1'b1;
                    end
                end
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (in_acc) begin
            if (in_sof) begin
                state_d = ST_EVEN_R;
            end else begin
                unique case (state_q)
                    ST_EVEN_L: state_d = ST_EVEN_R;
                    ST_EVEN_R: state_d = in_eol ? ST_ODD_L : ST_EVEN_L;
                    ST_ODD_L:  state_d = ST_ODD_R;
                    ST_ODD_R:  state_d = in_eol ? ST_EVEN_L : ST_ODD_L;
                    default:   state_d = ST_EVEN_L;
                endcase
            end
        end
    end

    // per-state strobes
    always_comb begin
        take_r  = 1'b0;
        wr_line = 1'b0;
        take_g2 = 1'b0;
        fire    = 1'b0;
        if (in_acc) begin
            if (in_sof) begin
                take_r = 1'b1;
            end else begin
                unique case (state_q)
                    ST_EVEN_L: take_r  = 1'b1;
                    ST_EVEN_R: wr_line = 1'b1;
                    ST_ODD_L:  take_g2 = 1'b1;
                    ST_ODD_R:  fire    = 1'b1;
                    default:   take_r  = 1'b0;
                endcase
            end
        end
    end

    assign state = state_q;
    assign qcol  = qcol_q;

endmodule

// File: rtl/bayer_quad_ct.sv
module bayer_quad_ct
    import bqct_pkg::*;
#(
    parameter int PIX_W     = 12,
    parameter int MAX_QUADS = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [PIX_W-1:0]        in_pix,
    input  logic                    in_sof,
    input  logic                    in_eol,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [PIX_W-1:0]        out_y,
    output logic signed [PIX_W:0]   out_u,
    output logic signed [PIX_W:0]   out_v,
    output logic signed [PIX_W:0]   out_d,
    output logic                    out_sof,
    output logic                    out_eol
);

    localparam int QW = (MAX_QUADS > 1) ? $clog2(MAX_QUADS) : 1;
    localparam int LW = 2 * PIX_W;

    bq_state_e         state;
    logic [QW-1:0]     qcol;
    logic              in_acc;
    logic              take_r, wr_line, take_g2, fire;
    logic [PIX_W-1:0]  r_hold, g2_hold;
    logic [LW-1:0]     line_rd;
    logic              sof_pend;

    logic [PIX_W-1:0]      y_c;
    logic signed [PIX_W:0] u_c, v_c, d_c;

    // Stall only a blue pixel while an untaken sample occupies the output.
    assign in_ready = !((state == ST_ODD_R) && out_valid && !out_ready);
    assign in_acc   = in_valid && in_ready;

    bqct_ctrl #(
        .MAX_QUADS(MAX_QUADS),
        .QW       (QW)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_acc (in_acc),
        .in_sof (in_sof),
        .in_eol (in_eol),
        .state  (state),
        .qcol   (qcol),
        .take_r (take_r),
        .wr_line(wr_line),
        .take_g2(take_g2),
        .fire   (fire)
    );

    bqct_line_buf #(
        .DW   (LW),
        .DEPTH(MAX_QUADS),
        .AW   (QW)
    ) u_line (
        .clk    (clk),
        .wr_en  (wr_line),
        .wr_addr(qcol),
        .wr_data({r_hold, in_pix}),
        .rd_addr(qcol),
        .rd_data(line_rd)
    );

    bqct_lift #(
        .PIX_W(PIX_W)
    ) u_lift (
        .r (line_rd[LW-1:PIX_W]),
        .g1(line_rd[PIX_W-1:0]),
        .g2(g2_hold),
        .b (in_pix),
        .y (y_c),
        .u (u_c),
        .v (v_c),
        .d (d_c)
    );

    // holding registers for the partial tile
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_hold  <= '0;
            g2_hold <= '0;
        end else begin
            if (take_r)  r_hold  <= in_pix;
            if (take_g2) g2_hold <= in_pix;
        end
    end

    // start-of-frame marker waiting for its first tile
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sof_pend <= 1'b0;
        end else if (in_acc && in_sof) begin
            sof_pend <= 1'b1;
        end else if (fire) begin
            sof_pend <= 1'b0;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_y     <= '0;
            out_u     <= '0;
            out_v     <= '0;
            out_d     <= '0;
            out_sof   <= 1'b0;
            out_eol   <= 1'b0;
        end else if (fire) begin
            out_valid <= 1'b1;
            out_y     <= y_c;
            out_u     <= u_c;
            out_v     <= v_c;
            out_d     <= d_c;
            out_sof   <= sof_pend;
            out_eol   <= in_eol;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/bqct_checker.sv
module bqct_checker #(
    parameter int PIX_W = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic [PIX_W-1:0]      out_y,
    input logic signed [PIX_W:0] out_u,
    input logic signed [PIX_W:0] out_v,
    input logic signed [PIX_W:0] out_d,
    input logic                  out_sof,
    input logic                  out_eol
);

    localparam int CW = PIX_W + 4;
    localparam logic signed [CW-1:0] MAXV = CW'((1 << PIX_W) - 1);

    logic signed [CW-1:0] sy, su, sv, sd, g_r, r_r, b_r, g1_r, g2_r;
    logic                 recon_ok;

    always_comb begin
        sy   = $signed({4'b0000, out_y});
        su   = CW'(out_u);
        sv   = CW'(out_v);
        sd   = CW'(out_d);
        g_r  = sy - ((su + sv) >>> 2);
        r_r  = su + g_r;
        b_r  = sv + g_r;
        g1_r = g_r + ((sd + 1) >>> 1);
        g2_r = g1_r - sd;
        recon_ok = (r_r >= 0) && (r_r <= MAXV) && (b_r >= 0) && (b_r <= MAXV) &&
                   (g1_r >= 0) && (g1_r <= MAXV) && (g2_r >= 0) && (g2_r <= MAXV);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R1: assert (!out_valid && in_ready);
        end
    end

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_y) && $stable(out_u) &&
        $stable(out_v) && $stable(out_d) && $stable(out_sof) && $stable(out_eol));

    assert_ready_unless_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || out_ready) |-> in_ready);

    assert_sample_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    assert_drain_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !(in_valid && in_ready) |=> !out_valid);

    assert_exact_inverse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> recon_ok);

endmodule

bind bayer_quad_ct bqct_checker #(.PIX_W(PIX_W)) u_bqct_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_y    (out_y),
    .out_u    (out_u),
    .out_v    (out_v),
    .out_d    (out_d),
    .out_sof  (out_sof),
    .out_eol  (out_eol)
);

// File: tb/bayer_quad_ct_test.sv
`timescale 1ns/1ps
module bayer_quad_ct_test;

    localparam int PIX_W = 12;
    localparam int MAXP  = (1 << PIX_W) - 1;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic                  in_ready;
    logic [PIX_W-1:0]      in_pix = '0;
    logic                  in_sof = 1'b0;
    logic                  in_eol = 1'b0;
    logic                  out_valid;
    logic                  out_ready = 1'b1;
    logic [PIX_W-1:0]      out_y;
    logic signed [PIX_W:0] out_u, out_v, out_d;
    logic                  out_sof, out_eol;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    int cap_y[256], cap_u[256], cap_v[256], cap_d[256], cap_sof[256], cap_eol[256];
    int n_out = 0;

    always #2 clk = ~clk;

    bayer_quad_ct #(.PIX_W(PIX_W), .MAX_QUADS(32)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .in_sof(in_sof), .in_eol(in_eol),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_y(out_y), .out_u(out_u), .out_v(out_v), .out_d(out_d),
        .out_sof(out_sof), .out_eol(out_eol)
    );

    // capture every completed output transfer
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && n_out < 256) begin
            cap_y[n_out]   = int'(out_y);
            cap_u[n_out]   = int'(out_u);
            cap_v[n_out]   = int'(out_v);
            cap_d[n_out]   = int'(out_d);
            cap_sof[n_out] = int'(out_sof);
            cap_eol[n_out] = int'(out_eol);
            n_out++;
        end
    end

    task automatic check_int(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // pixel pattern: seed >= 0 gives distinct values, seed < 0 gives extreme tiles
    function automatic int pixv(input int row, input int col, input int seed);
        int p, j, mask;
        if (seed >= 0) return (row * 577 + col * 1031 + seed * 389 + 13) % (MAXP + 1);
        p = (row % 2) * 2 + (col % 2);
        j = (col / 2) % 4;
        case (j)
            0: mask = 4'b1111;
            1: mask = 4'b1001;
            2: mask = 4'b0010;
            default: mask = 4'b0100;
        endcase
        return mask[p] ? MAXP : 0;
    endfunction

    // transfers one pixel; starts and returns just after a rising edge
    task automatic send_pix(input int val, input bit sof, input bit eol);
        bit acc;
        in_valid = 1'b1;
        in_pix   = PIX_W'(val);
        in_sof   = sof;
        in_eol   = eol;
        do begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk);
            #1;
        end while (!acc);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eol   = 1'b0;
    endtask

    task automatic send_frame(input int cols, input int rows, input int seed);
        for (int r = 0; r < rows; r++)
            for (int c = 0; c < cols; c++)
                send_pix(pixv(r, c, seed), (r == 0 && c == 0), (c == cols - 1));
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        #1;
    endtask

    // compares captured samples from index base against the lifting equations
    task automatic check_frame(input int base, input int cols, input int rows, input int seed);
        int qpr, R, G1, G2, B, G, U, V, D, Y, idx, gr, g1r;
        qpr = cols / 2;
        check_int("R4", "sample count", n_out - base, qpr * (rows / 2));
        for (int k = 0; k < rows / 2; k++) begin
            for (int j = 0; j < qpr; j++) begin
                idx = base + k * qpr + j;
                R  = pixv(2 * k, 2 * j, seed);
                G1 = pixv(2 * k, 2 * j + 1, seed);
                G2 = pixv(2 * k + 1, 2 * j, seed);
                B  = pixv(2 * k + 1, 2 * j + 1, seed);
                G  = (G1 + G2) >>> 1;
                D  = G1 - G2;
                U  = R - G;
                V  = B - G;
                Y  = G + ((U + V) >>> 2);
                check_int("R2/R5", "Y", cap_y[idx], Y);
                check_int("R2/R5", "U", cap_u[idx], U);
                check_int("R2/R5", "V", cap_v[idx], V);
                check_int("R2/R5", "D", cap_d[idx], D);
                check_int("R6", "sof flag", cap_sof[idx], (k == 0 && j == 0) ? 1 : 0);
                check_int("R7", "eol flag", cap_eol[idx], (j == qpr - 1) ? 1 : 0);
                gr  = cap_y[idx] - ((cap_u[idx] + cap_v[idx]) >>> 2);
                g1r = gr + ((cap_d[idx] + 1) >>> 1);
                check_int("R3", "inverse R", cap_u[idx] + gr, R);
                check_int("R3", "inverse B", cap_v[idx] + gr, B);
                check_int("R3", "inverse G1", g1r, G1);
                check_int("R3", "inverse G2", g1r - cap_d[idx], G2);
            end
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check_int("R1", "out_valid in reset", int'(out_valid), 0);
        check_int("R1", "in_ready in reset", int'(in_ready), 1);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check_int("R1", "out_valid after reset", int'(out_valid), 0);
        check_int("R1", "in_ready after reset", int'(in_ready), 1);
        @(posedge clk);
        #1;
    endtask

    task automatic test_small_frame();
        int base = n_out;
        send_frame(4, 2, 1);
        settle();
        check_frame(base, 4, 2, 1);
    endtask

    task automatic test_multi_row();
        int base = n_out;
        int seen;
        // even row only: no sample may appear (R4)
        for (int c = 0; c < 8; c++) send_pix(pixv(0, c, 2), c == 0, c == 7);
        settle();
        check_int("R4", "no sample during even row", n_out - base, 0);
        for (int r = 1; r < 4; r++)
            for (int c = 0; c < 8; c++) send_pix(pixv(r, c, 2), 1'b0, c == 7);
        settle();
        seen = n_out;
        check_frame(base, 8, 4, 2);
        check_int("R4", "no extra samples", n_out, seen);
    endtask

    task automatic test_extremes();
        int base = n_out;
        send_frame(8, 2, -1);
        settle();
        check_frame(base, 8, 2, -1);
        check_int("R10", "all-max Y", cap_y[base], MAXP);
        check_int("R10", "all-max U", cap_u[base], 0);
        check_int("R10", "all-max D", cap_d[base], 0);
        check_int("R10", "G1-only D", cap_d[base + 2], MAXP);
        check_int("R10", "G1-only U", cap_u[base + 2], -((MAXP + 1) / 2 - 1));
        check_int("R10", "G1-only Y", cap_y[base + 2], (MAXP + 1) / 4 - 1);
    endtask

    task automatic test_backpressure();
        int base = n_out;
        int y0;
        out_ready = 1'b0;
        for (int c = 0; c < 4; c++) send_pix(pixv(0, c, 3), c == 0, c == 3);
        send_pix(pixv(1, 0, 3), 1'b0, 1'b0);
        send_pix(pixv(1, 1, 3), 1'b0, 1'b0);
        send_pix(pixv(1, 2, 3), 1'b0, 1'b0);   // green accepted during stall
        @(negedge clk);
        check_int("R8", "held valid", int'(out_valid), 1);
        check_int("R8", "blue stalled", int'(in_ready), 0);
        y0 = int'(out_y);
        fork
            send_pix(pixv(1, 3, 3), 1'b0, 1'b1);
            begin
                repeat (4) begin
                    @(negedge clk);
                    check_int("R8", "held Y stable", int'(out_y), y0);
                    check_int("R8", "still stalled", int'(in_ready), 0);
                end
                @(posedge clk);
                #1;
                out_ready = 1'b1;
            end
        join
        settle();
        check_frame(base, 4, 2, 3);
    endtask

    task automatic test_resync();
        int base;
        for (int c = 0; c < 4; c++) send_pix(pixv(0, c, 4), c == 0, c == 3);
        send_pix(pixv(1, 0, 4), 1'b0, 1'b0);   // half tile left open
        base = n_out;
        send_frame(2, 2, 5);
        settle();
        check_int("R9", "only new frame emitted", n_out - base, 1);
        check_frame(base, 2, 2, 5);
        base = n_out;
        send_frame(4, 2, 6);
        settle();
        check_frame(base, 4, 2, 6);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_small_frame();
        test_multi_row();
        test_extremes();
        test_backpressure();
        test_resync();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule